// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records the moment at which a slow external signal changes. A timestamp counter runs from the core clock through a power-of-two prescaler, and each selected transition of the input writes the current timestamp into an eight-entry queue. Software, or a downstream engine, drains the queue one 32-bit word at a time through a valid/ready read port. The word's bits [7:0] form the byte that comes first when the word is sent as a little-endian byte sequence.

The unit counts and captures only while it is enabled and its mode select picks timestamp capture. When that select picks the counting mode, the capture path stays idle, so a shared quadrature counter can own the pins. The input is asynchronous and passes through a synchroniser before edge detection. Two sticky event flags report, in turn, that a new entry has arrived and that the queue occupancy has reached a programmable threshold. Each flag is cleared by a one-cycle clear pulse. Removing the enable empties the queue and restarts the time base.

The read port follows valid/ready rules. `rd_valid` is high whenever the queue holds an entry. `rd_data` shows the oldest entry and does not change while `rd_valid` is high and `rd_ready` is low. An entry is removed on a cycle in which both signals are high. A consumer may keep `rd_ready` high at all times. With the queue empty, `rd_ready` has no effect.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset, `fifo_empty` is 1 and `rd_valid`, `rd_data`, `overflow`, `irq_entry` and `irq_crit` are all 0.
- R2: Captures and timestamp counting happen only while `enable` is 1 and `capture_sel` is 1. With `capture_sel` at 0, input edges add no entry.
- R3: When `both_edges` is 0, only rising input edges are captured and falling edges are ignored. When `both_edges` is 1, both rising and falling edges are captured.
- R4: The timestamp advances once every 2^`div_exp` clock cycles, beginning from 0 at the enabling edge. An input change driven d cycles after `enable` is raised stores floor((d+2)/2^`div_exp`) and becomes visible on the read port three clock edges after the change.
- R5: The read port returns entries oldest first. While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays at 1 and `rd_data` does not change.
- R6: While the queue is empty, `rd_valid` is 0, `fifo_empty` is 1 and `rd_data` is 0. Asserting `rd_ready` in that state removes nothing, so the next capture is the next word read.
- R7: The queue holds 8 entries. A capture that arrives while the queue is full is dropped, even if an entry is read in the same cycle, and it sets `overflow`. `overflow` then stays at 1 while the unit remains enabled.
- R8: `irq_entry` is set by every accepted capture and stays set until an `irq_clr_entry` pulse clears it. If a capture and a clear fall in the same cycle, the capture wins.
- R9: `irq_crit` is set when an accepted capture leaves the queue occupancy at or above `thr_code`+1, where the 3-bit code 0..7 means 1..8 entries. It stays set until an `irq_clr_crit` pulse clears it.
- R10: Dropping `enable` to 0 empties the queue, clears `overflow`, and resets the prescaler and the timestamp to 0. `irq_entry` and `irq_crit` are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Unit enable; low flushes the queue and the time base |
| capture_sel | input | 1 | 1 selects timestamp capture, 0 selects the counting mode (capture idle) |
| both_edges | input | 1 | 1 captures both edges, 0 captures rising edges only |
| div_exp | input | 5 | Prescaler exponent k; the timestamp advances every 2^k cycles |
| thr_code | input | 3 | Critical threshold minus one |
| sig_in | input | 1 | Asynchronous input being timestamped |
| rd_valid | output | 1 | Oldest entry is available |
| rd_ready | input | 1 | Consumer accepts the entry |
| rd_data | output | 32 | Oldest timestamp, or 0 when empty |
| fifo_empty | output | 1 | No entry is waiting |
| overflow | output | 1 | Sticky: a capture was dropped because the queue was full |
| irq_entry | output | 1 | Sticky new-entry event |
| irq_crit | output | 1 | Sticky threshold-reached event |
| irq_clr_entry | input | 1 | Clear pulse for irq_entry |
| irq_clr_crit | input | 1 | Clear pulse for irq_crit |

## Verification
An input change takes three clock edges to reach the read port: two in the synchroniser and one in the edge register that writes the queue. The stored value is floor((d+2)/2^k) for a change driven d cycles after the enable. Flags, `overflow` and the effect of a disable or a read appear one edge after the stimulus. The bench drives on falling clock edges, waits exactly that many rising edges, and samples on the next falling edge. It predicts every queued value from the cycle counts it has recorded itself.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
  // Synchronised edge events presented to the capture control.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_pair_t;

  // Capture qualification for one cycle.
  function automatic logic capture_hit(input edge_pair_t e, input logic both);
    return e.rise | (both & e.fall);
  endfunction
endpackage

// File: rtl/esc_edge_sync.sv
module esc_edge_sync
  import edge_stamp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig,
  output edge_pair_t edges
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("esc_edge_sync needs at least two stages");
    end
  endgenerate

  // Metastability chain: stage 0 samples the raw pin.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= sig;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[LAST];
  end

  always_comb begin
    edges.rise = chain[LAST] & ~prev_q;
    edges.fall = ~chain[LAST] & prev_q;
  end
endmodule

// File: rtl/esc_timebase.sv
module esc_timebase #(
  parameter int TS_W  = 32,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] k,
  output logic [TS_W-1:0]  ts
);
  localparam int PRE_W = 1 << DIV_W;
  localparam logic [PRE_W-1:0] ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             tick;

  // Low k bits all ones marks the last cycle of each 2^k window.
  always_comb begin
    mask = (ONE << k) - ONE;
    tick = run && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ts    <= '0;
    end else if (clear) begin
      pre_q <= '0;
      ts    <= '0;
    end else if (run) begin
      pre_q <= pre_q + ONE;
      if (tick) ts <= ts + {{(TS_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/esc_fifo.sv
module esc_fifo #(
  parameter int  W     = 32,
  parameter int  DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic [CNT_W-1:0] count,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    full      = (cnt_q == FULL_C);
    out_valid = (cnt_q != '0);
    out_data  = out_valid ? mem[rptr_q] : '0;
    // A full queue refuses a write even when a read drains it this cycle.
    push_ok   = push && !full && !flush;
    pop_ok    = out_valid && out_ready && !flush;
    count     = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= adv(wptr_q);
      if (pop_ok)  rptr_q <= adv(rptr_q);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= din;
  end
endmodule

// File: rtl/esc_irq.sv
module esc_irq #(
  parameter int THR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic [CNT_W-1:0] count,
  input  logic [THR_W-1:0] thr_code,
  input  logic             clr_entry,
  input  logic             clr_crit,
  output logic             irq_entry,
  output logic             irq_crit
);
  logic [CNT_W:0] level_after;
  logic [THR_W:0] thr_n;
  logic           crit_hit;

  always_comb begin
    level_after = {1'b0, count} + (CNT_W+1)'(!pop_ok);
    thr_n       = {1'b0, thr_code} + (THR_W+1)'(1);
    crit_hit    = push_ok && (32'(level_after) >= 32'(thr_n));
  end

  // Set has priority over the clear pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_entry <= 1'b0;
      irq_crit  <= 1'b0;
    end else begin
      if (push_ok)        irq_entry <= 1'b1;
      else if (clr_entry) irq_entry <= 1'b0;
      if (crit_hit)       irq_crit  <= 1'b1;
      else if (clr_crit)  irq_crit  <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
  import edge_stamp_pkg::*;
#(
  parameter int TS_W        = 32,
  parameter int DEPTH       = 8,
  parameter int DIV_W       = 5,
  parameter int THR_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             capture_sel,
  input  logic             both_edges,
  input  logic [DIV_W-1:0] div_exp,
  input  logic [THR_W-1:0] thr_code,
  input  logic             sig_in,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [TS_W-1:0]  rd_data,
  output logic             fifo_empty,
  output logic             overflow,
  output logic             irq_entry,
  output logic             irq_crit,
  input  logic             irq_clr_entry,
  input  logic             irq_clr_crit
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  edge_pair_t       edges;
  logic             run;
  logic             capture;
  logic [TS_W-1:0]  ts;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok;
  logic             ovf_q;

  esc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   (sig_in),
    .edges (edges)
  );

  always_comb begin
    run     = enable && capture_sel;
    capture = run && capture_hit(edges, both_edges);
  end

  esc_timebase #(.TS_W(TS_W), .DIV_W(DIV_W)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!enable),
    .run   (run),
    .k     (div_exp),
    .ts    (ts)
  );

  esc_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!enable),
    .push      (capture),
    .din       (ts),
    .out_ready (rd_ready),
    .out_valid (rd_valid),
    .out_data  (rd_data),
    .count     (count),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok)
  );

  esc_irq #(.THR_W(THR_W), .CNT_W(CNT_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .count     (count),
    .thr_code  (thr_code),
    .clr_entry (irq_clr_entry),
    .clr_crit  (irq_clr_crit),
    .irq_entry (irq_entry),
    .irq_crit  (irq_crit)
  );

  // Sticky drop flag, cleared only by disabling.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovf_q <= 1'b0;
    else if (!enable)            ovf_q <= 1'b0;
    else if (capture && !push_ok) ovf_q <= 1'b1;
  end

  always_comb begin
    overflow   = ovf_q;
    fifo_empty = (count == '0);
  end
endmodule

// File: rtl/edge_stamp_capture_chk.sv
module edge_stamp_capture_chk #(
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            capture_sel,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [TS_W-1:0] rd_data,
  input logic            fifo_empty,
  input logic            overflow,
  input logic            irq_entry,
  input logic            irq_crit
);
  // R6
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (fifo_empty && !overflow));

  // R7
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && overflow) |=> overflow);

  // R8
  entry_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_entry) |-> !fifo_empty);

  // R9
  crit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_crit) |-> !fifo_empty);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && enable) |=> (rd_valid && $stable(rd_data)));

  // R2
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !capture_sel && fifo_empty) |=> fifo_empty);
endmodule

bind edge_stamp_capture edge_stamp_capture_chk #(.TS_W(TS_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .capture_sel (capture_sel),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data),
  .fifo_empty  (fifo_empty),
  .overflow    (overflow),
  .irq_entry   (irq_entry),
  .irq_crit    (irq_crit)
);

// File: tb/edge_stamp_capture_tb_top.sv
`timescale 1ns/1ps
module edge_stamp_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, capture_sel = 1'b0, both_edges = 1'b0;
  logic [4:0]  div_exp = '0;
  logic [2:0]  thr_code = '0;
  logic        sig_in = 1'b0, rd_ready = 1'b0;
  logic        irq_clr_entry = 1'b0, irq_clr_crit = 1'b0;
  logic        rd_valid, fifo_empty, overflow, irq_entry, irq_crit;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  int cyc = 0, t_en = 0, k_cur = 0;
  logic [31:0] mq [16];
  int mhead = 0, mcount = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edge_stamp_capture dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .capture_sel(capture_sel),
    .both_edges(both_edges), .div_exp(div_exp), .thr_code(thr_code),
    .sig_in(sig_in), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .fifo_empty(fifo_empty), .overflow(overflow),
    .irq_entry(irq_entry), .irq_crit(irq_crit),
    .irq_clr_entry(irq_clr_entry), .irq_clr_crit(irq_clr_crit)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic start(input int k, input bit both, input int thr, input bit capsel);
    @(negedge clk);
    enable = 0; irq_clr_entry = 1; irq_clr_crit = 1;
    @(negedge clk);
    irq_clr_entry = 0; irq_clr_crit = 0;
    div_exp = 5'(k); both_edges = both; thr_code = 3'(thr); capture_sel = capsel;
    enable = 1; t_en = cyc; k_cur = k; mhead = 0; mcount = 0;
  endtask

  // Toggle the input, predict the entry, wait until it is visible.
  task automatic toggle();
    bit cap;
    @(negedge clk);
    sig_in = ~sig_in;
    cap = enable && capture_sel && (sig_in || both_edges);
    if (cap && mcount < 8) begin
      mq[(mhead + mcount) % 16] = 32'((cyc - t_en + 2) >> k_cur);
      mcount++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_chk(input string tag);
    chk(rd_valid == 1'b1, {tag, " valid"}, 32'(rd_valid), 1);
    chk(rd_data == mq[mhead], {tag, " data"}, rd_data, mq[mhead]);
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
    mhead = (mhead + 1) % 16; mcount--;
  endtask

  task automatic t_reset();
    chk(fifo_empty == 1, "R1 empty", 32'(fifo_empty), 1);
    chk(rd_valid == 0 && rd_data == 0, "R1 read port", rd_data, 0);
    chk(!overflow && !irq_entry && !irq_crit, "R1 flags", {29'd0, overflow, irq_entry, irq_crit}, 0);
  endtask

  task automatic t_mode_off();
    start(0, 1, 7, 0);
    toggle(); toggle();
    chk(fifo_empty == 1, "R2 counting mode adds nothing", 32'(fifo_empty), 1);
  endtask

  task automatic t_single_edge();
    start(0, 0, 7, 1);
    repeat (5) @(negedge clk);
    toggle();
    chk(irq_entry == 1, "R8 entry flag", 32'(irq_entry), 1);
    toggle();
    pop_chk("R4 rising stamp");
    chk(rd_valid == 0, "R3 falling ignored", 32'(rd_valid), 0);
  endtask

  task automatic t_both_edges();
    start(0, 1, 7, 1);
    toggle(); repeat (4) @(negedge clk); toggle();
    pop_chk("R3 both first");
    pop_chk("R5 order second");
  endtask

  task automatic t_prescale(input int k);
    start(k, 1, 7, 1);
    repeat (9) @(negedge clk); toggle();
    repeat (21) @(negedge clk); toggle();
    pop_chk($sformatf("R4 k=%0d first", k));
    pop_chk($sformatf("R4 k=%0d second", k));
  endtask

  task automatic t_empty_read();
    start(0, 1, 7, 1);
    @(negedge clk); rd_ready = 1;
    repeat (2) @(negedge clk);
    chk(rd_valid == 0 && rd_data == 0, "R6 empty read zero", rd_data, 0);
    rd_ready = 0;
    toggle();
    pop_chk("R6 pointer unmoved");
  endtask

  task automatic t_hold();
    logic [31:0] first;
    start(0, 1, 7, 1);
    toggle(); toggle();
    first = rd_data;
    repeat (5) @(negedge clk);
    chk(rd_valid && rd_data == first, "R5 held under back-pressure", rd_data, first);
    pop_chk("R5 head after hold");
    pop_chk("R5 second after hold");
  endtask

  task automatic t_threshold();
    start(0, 1, 2, 1);
    toggle(); toggle();
    chk(irq_crit == 0, "R9 below threshold", 32'(irq_crit), 0);
    toggle();
    chk(irq_crit == 1, "R9 threshold reached", 32'(irq_crit), 1);
    @(negedge clk); irq_clr_entry = 1;
    @(negedge clk); irq_clr_entry = 0;
    chk(irq_entry == 0 && irq_crit == 1, "R8 clear entry only", {30'd0, irq_entry, irq_crit}, 1);
    @(negedge clk); irq_clr_crit = 1;
    @(negedge clk); irq_clr_crit = 0;
    chk(irq_crit == 0, "R9 clear crit", 32'(irq_crit), 0);
  endtask

  task automatic t_overflow();
    start(0, 1, 7, 1);
    for (int i = 0; i < 8; i++) toggle();
    chk(overflow == 0, "R7 full no overflow yet", 32'(overflow), 0);
    toggle();
    chk(overflow == 1, "R7 overflow set", 32'(overflow), 1);
    for (int i = 0; i < 8; i++) pop_chk("R7 kept entry");
    chk(rd_valid == 0, "R7 dropped capture absent", 32'(rd_valid), 0);
    chk(overflow == 1, "R7 overflow sticky", 32'(overflow), 1);
  endtask

  task automatic t_disable();
    start(0, 1, 7, 1);
    repeat (40) @(negedge clk);
    toggle(); toggle();
    @(negedge clk); enable = 0;
    @(negedge clk);
    chk(fifo_empty == 1 && overflow == 0, "R10 flushed", 32'(fifo_empty), 1);
    chk(irq_entry == 1, "R10 entry flag kept", 32'(irq_entry), 1);
    enable = 1; t_en = cyc; mhead = 0; mcount = 0;
    repeat (3) @(negedge clk);
    toggle();
    pop_chk("R10 timestamp restarted");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_mode_off();
    t_single_edge();
    t_both_edges();
    t_prescale(2);
    t_prescale(3);
    t_empty_read();
    t_hold();
    t_threshold();
    t_overflow();
    t_disable();
    done = 1;
    summary();
  end
endmodule